// File: doc/BRIEF.md
# Successive-Approximation Converter Control Sequencer

This block is the digital core of a 14-bit successive-approximation converter. A host steers it through two pins only: an active-low chip select and a read/convert level. Successive falling edges of chip select walk the block through three phases. The first phase wakes the block and starts sampling. The second phase freezes the sample and runs the conversion. The third phase places the result on an 8-bit bus. A high-byte select picks which half of the result the bus carries. The analog parts are outside the block. It drives a trial code toward the capacitive DAC and reads back one comparator bit that reports whether the held sample is at or above that trial level.

Each bit decision lasts a fixed number of internal clock cycles, set by a parameter, so that all 14 decisions fit inside the conversion budget. An active-low end-of-conversion flag tells the host when the result is ready. The read/convert level at the second edge selects what happens to the reference after conversion. In standby the reference stays on, and the next cycle can begin acquisition at once. In shutdown the reference is switched off, and the next wake-up waits for a reference-ready input. The stored code is the plain SAR code, so a bipolar front end yields offset binary and a unipolar one yields straight binary without any change in the logic.

Top module: `sar_seq_top`

## Requirements
- R1: After synchronous reset, eoc_n is 1, dbus_oe is 0, dbus is 0, ref_en is 0, shdn_sel is 1 and sample_hold is 0.
- R2: A chip-select falling edge while idle with rd_cnv high is ignored: ref_en stays 0 and no acquisition begins.
- R3: A chip-select falling edge while idle with rd_cnv low sets ref_en on the following clock. If the reference was off, acquisition begins only once ref_ok is 1, and chip-select edges before that are ignored (sample_hold stays 0).
- R4: The chip-select falling edge during acquisition raises sample_hold on the next clock. eoc_n falls exactly 14*TICKS_PER_BIT+1 clocks after sample_hold rises, and sample_hold drops at that same moment.
- R5: Conversion is MSB first. Bit k is kept as 1 when cmp_hi is 1 while trial_code holds the kept bits plus bit k. For a comparator that reports sample >= trial, the result equals the sample code for every code from 0 to 16383.
- R6: The rd_cnv level at the conversion-start edge is latched into shdn_sel (1 means shutdown). With shutdown selected, ref_en drops when eoc_n falls. With standby selected, ref_en stays 1 and the next wake-up edge goes straight to acquisition.
- R7: dbus_oe is 1 only after a chip-select falling edge with rd_cnv high while eoc_n is low. During acquisition and conversion, dbus_oe is 0 and dbus reads 0.
- R8: While the bus is driven, hb_sel=1 puts result bits 13:8 on dbus lanes 5:0 with lanes 7:6 at 0, and hb_sel=0 puts result bits 7:0 on lanes 7:0.
- R9: The clock after chip select is seen high in the read phase, dbus_oe returns to 0 and eoc_n returns to 1.
- R10: A chip-select falling edge with rd_cnv low while a result is waiting is ignored: the bus stays off and eoc_n stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low; falling edges step the sequence |
| rd_cnv | input | 1 | Read/convert level sampled at each chip-select falling edge |
| hb_sel | input | 1 | High-byte select for the output bus |
| cmp_hi | input | 1 | Comparator: held sample is at or above trial_code |
| ref_ok | input | 1 | Reference has settled |
| trial_code | output | 14 | Code presented to the DAC |
| sample_hold | output | 1 | 1 while the sample is held and converted |
| eoc_n | output | 1 | End of conversion, active low |
| ref_en | output | 1 | Reference and buffer power enable |
| shdn_sel | output | 1 | Latched power mode after conversion (1 = shutdown) |
| dbus_oe | output | 1 | Output enable for the three-state data bus |
| dbus | output | 8 | Data bus lanes (0 when not enabled) |

## Verification
The checker assumes that cs_n and rd_cnv are synchronous to clk and that rd_cnv is stable at each edge where cs_n is first seen low. It also assumes that cmp_hi answers the trial code presented in the same cycle and that ref_ok stays low while ref_en is low. The bench changes every input just after a falling clock edge. Its comparator is a combinational compare of a fixed target against trial_code. Its ref_ok goes high only after a counted delay from ref_en and drops with ref_en, so every property sees inputs of the shape it assumes.

// File: rtl/sar_seq_pkg.sv
// Shared types for the SAR control sequencer.
// Assumes nothing beyond a single clock domain.
package sar_seq_pkg;

    // Phases of the chip-select driven sequence.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAKE = 3'd1,
        ST_ACQ  = 3'd2,
        ST_CONV = 3'd3,
        ST_DONE = 3'd4,
        ST_READ = 3'd5
    } seq_st_t;

endpackage

// File: rtl/sar_cs_decode.sv
// Chip-select edge decoder: flags the first cycle in which cs_n is seen low
// after having been high. Assumes cs_n is synchronous to clk.
module sar_cs_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_fall
);

    logic cs_q;

    // Remember the previous chip-select level (idle high after reset).
    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= 1'b1;
        else        cs_q <= cs_n;
    end

    // A falling edge is a high-to-low change between two samples.
    always_comb begin
        cs_fall = cs_q & ~cs_n;
    end

endmodule

// File: rtl/sar_seq_fsm.sv
// Sequence controller: counts chip-select falling edges into wake-up,
// acquisition, conversion, result-waiting and read phases, and owns the
// reference power enable and the latched power mode.
// Assumes conv_done is a one-cycle pulse from the step engine.
module sar_seq_fsm
    import sar_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_fall,
    input  logic cs_n,
    input  logic rd_cnv,
    input  logic ref_ok,
    input  logic conv_done,
    output logic start_conv,
    output logic sample_hold,
    output logic eoc_n,
    output logic bus_en,
    output logic ref_en,
    output logic shdn_sel
);

    seq_st_t st_q;
    logic    ref_q;
    logic    shdn_q;

    // Phase register, reference power and power-mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            ref_q  <= 1'b0;
            shdn_q <= 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (cs_fall && !rd_cnv) begin
                        ref_q <= 1'b1;
                        st_q  <= ref_q ? ST_ACQ : ST_WAKE;
                    end
                end
                ST_WAKE: begin
                    if (ref_ok) st_q <= ST_ACQ;
                end
                ST_ACQ: begin
                    if (cs_fall) begin
                        st_q   <= ST_CONV;
                        shdn_q <= rd_cnv;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        st_q <= ST_DONE;
                        if (shdn_q) ref_q <= 1'b0;
                    end
                end
                ST_DONE: begin
                    if (cs_fall && rd_cnv) st_q <= ST_READ;
                end
                ST_READ: begin
                    if (cs_n) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Decode phase-level outputs.
    always_comb begin
        start_conv  = (st_q == ST_ACQ) && cs_fall;
        sample_hold = (st_q == ST_CONV);
        eoc_n       = !((st_q == ST_DONE) || (st_q == ST_READ));
        bus_en      = (st_q == ST_READ);
        ref_en      = ref_q;
        shdn_sel    = shdn_q;
    end

endmodule

// File: rtl/sar_step_engine.sv
// Successive-approximation engine: decides one result bit per
// TICKS_PER_BIT clocks, MSB first, from the comparator bit answering the
// trial code it presents. Assumes cmp_hi settles within one clock.
module sar_step_engine #(
    parameter int RES_W         = 14,
    parameter int TICKS_PER_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [RES_W-1:0] trial_code,
    output logic [RES_W-1:0] result,
    output logic             done
);

    localparam int IDX_W = $clog2(RES_W);
    localparam int TK_W  = $clog2(TICKS_PER_BIT + 1);
    localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(RES_W - 1);
    localparam logic [TK_W-1:0]  LAST_TK  = TK_W'(TICKS_PER_BIT - 1);

    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [TK_W-1:0]  tick_q;
    logic [RES_W-1:0] acc_q;
    logic             done_q;
    logic             last_tick;
    logic [RES_W-1:0] trial_mask;

    // Bit-step timing, decision capture and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            tick_q <= '0;
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                busy_q <= 1'b1;
                idx_q  <= TOP_IDX;
                tick_q <= '0;
                acc_q  <= '0;
            end else if (busy_q) begin
                if (last_tick) begin
                    acc_q[idx_q] <= cmp_hi;
                    tick_q       <= '0;
                    if (idx_q == '0) begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end
        end
    end

    // Trial code: kept bits plus the bit under test.
    always_comb begin
        last_tick  = (tick_q == LAST_TK);
        trial_mask = busy_q ? (RES_W'(1) << idx_q) : '0;
        trial_code = acc_q | trial_mask;
        result     = acc_q;
        done       = done_q;
    end

endmodule

// File: rtl/sar_byte_mux.sv
// Output byte selector: splits the result into a low byte and a
// zero-padded high byte and gates the bus off when not enabled.
// Assumes BUS_W < RES_W <= 2*BUS_W.
module sar_byte_mux #(
    parameter int RES_W = 14,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             hb_sel,
    input  logic             en,
    output logic [BUS_W-1:0] dbus
);

    localparam int HI_W = RES_W - BUS_W;

    logic [BUS_W-1:0] hi_lane;

    // Build each high-byte lane: a result bit or a constant zero pad.
    for (genvar i = 0; i < BUS_W; i++) begin : g_lane
        if (i < HI_W) begin : g_bit
            assign hi_lane[i] = result[BUS_W+i];
        end else begin : g_pad
            assign hi_lane[i] = 1'b0;
        end
    end

    // Pick the byte and force zero while the bus is released.
    always_comb begin
        if (!en)         dbus = '0;
        else if (hb_sel) dbus = hi_lane;
        else             dbus = result[BUS_W-1:0];
    end

endmodule

// File: rtl/sar_seq_top.sv
// Top of the SAR control sequencer: chip-select decoding, phase control,
// bit-step engine and output byte selection.
// Assumes all inputs are synchronous to clk.
module sar_seq_top #(
    parameter int RES_W         = 14,
    parameter int BUS_W         = 8,
    parameter int TICKS_PER_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_cnv,
    input  logic             hb_sel,
    input  logic             cmp_hi,
    input  logic             ref_ok,
    output logic [RES_W-1:0] trial_code,
    output logic             sample_hold,
    output logic             eoc_n,
    output logic             ref_en,
    output logic             shdn_sel,
    output logic             dbus_oe,
    output logic [BUS_W-1:0] dbus
);

    logic             cs_fall;
    logic             start_conv;
    logic             conv_done;
    logic             bus_en;
    logic [RES_W-1:0] result;

    sar_cs_decode u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_fall (cs_fall)
    );

    sar_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_fall     (cs_fall),
        .cs_n        (cs_n),
        .rd_cnv      (rd_cnv),
        .ref_ok      (ref_ok),
        .conv_done   (conv_done),
        .start_conv  (start_conv),
        .sample_hold (sample_hold),
        .eoc_n       (eoc_n),
        .bus_en      (bus_en),
        .ref_en      (ref_en),
        .shdn_sel    (shdn_sel)
    );

    sar_step_engine #(
        .RES_W         (RES_W),
        .TICKS_PER_BIT (TICKS_PER_BIT)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_conv),
        .cmp_hi     (cmp_hi),
        .trial_code (trial_code),
        .result     (result),
        .done       (conv_done)
    );

    sar_byte_mux #(
        .RES_W (RES_W),
        .BUS_W (BUS_W)
    ) u_mux (
        .result (result),
        .hb_sel (hb_sel),
        .en     (bus_en),
        .dbus   (dbus)
    );

    // Bus enable mirrors the read phase.
    always_comb begin
        dbus_oe = bus_en;
    end

endmodule

// File: rtl/sar_seq_chk.sv
// Protocol checker for sar_seq_top, attached by bind.
// Assumes inputs synchronous to clk and ref_ok low while ref_en is low.
module sar_seq_chk #(
    parameter int RES_W = 14,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             hb_sel,
    input logic             sample_hold,
    input logic             eoc_n,
    input logic             ref_en,
    input logic             dbus_oe,
    input logic [BUS_W-1:0] dbus
);

    localparam int HI_W = RES_W - BUS_W;

    p_hold_needs_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> ref_en);

    p_eoc_after_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eoc_n) |-> $past(sample_hold));

    p_ref_off_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_en) |-> $past(sample_hold));

    p_bus_after_eoc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dbus_oe |-> !eoc_n);

    p_bus_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !dbus_oe |-> (dbus == '0));

    p_hi_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbus_oe && hb_sel) |-> (dbus[BUS_W-1:HI_W] == '0));

    p_eoc_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc_n) |-> $past(cs_n));

endmodule

bind sar_seq_top sar_seq_chk #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .hb_sel      (hb_sel),
    .sample_hold (sample_hold),
    .eoc_n       (eoc_n),
    .ref_en      (ref_en),
    .dbus_oe     (dbus_oe),
    .dbus        (dbus)
);

// File: tb/sar_seq_top_test.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model plus directed conversion checks.
module sar_seq_top_test;

    localparam int TPB = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_cnv = 1'b0;
    logic        hb_sel = 1'b0;
    logic        ref_ok = 1'b0;
    logic        cmp_hi;
    logic [13:0] trial_code;
    logic        sample_hold, eoc_n, ref_en, shdn_sel, dbus_oe;
    logic [7:0]  dbus;

    int tgt = 0;
    int checks = 0;
    int fails = 0;
    int rcnt = 0;

    always #2.5 clk = ~clk;

    sar_seq_top #(.RES_W(14), .BUS_W(8), .TICKS_PER_BIT(TPB)) uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_cnv(rd_cnv),
        .hb_sel(hb_sel), .cmp_hi(cmp_hi), .ref_ok(ref_ok),
        .trial_code(trial_code), .sample_hold(sample_hold), .eoc_n(eoc_n),
        .ref_en(ref_en), .shdn_sel(shdn_sel), .dbus_oe(dbus_oe), .dbus(dbus)
    );

    // Comparator stand-in: held sample at or above the trial level.
    assign cmp_hi = (tgt >= int'(trial_code));

    // Reference settling stand-in: ready 20 clocks after power-on.
    always @(negedge clk) begin
        if (!ref_en) begin
            rcnt = 0;
            ref_ok <= 1'b0;
        end else if (rcnt < 20) rcnt = rcnt + 1;
        else ref_ok <= 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // ---- behavioural reference model ----
    int m_ph = 0;      // 0 idle 1 wake 2 acq 3 conv 4 done 5 read
    int m_cnt = 0;
    bit m_ref = 0, m_shd = 1, m_csq = 1;
    int m_res = 0;

    always @(posedge clk) begin
        bit fall;
        if (!rst_n) begin
            m_ph = 0; m_ref = 0; m_shd = 1; m_csq = 1;
        end else begin
            fall = m_csq && !cs_n;
            case (m_ph)
                0: if (fall && !rd_cnv) begin m_ph = m_ref ? 2 : 1; m_ref = 1; end
                1: if (ref_ok) m_ph = 2;
                2: if (fall) begin m_ph = 3; m_shd = rd_cnv; m_cnt = 0; end
                3: begin
                    m_cnt++;
                    if (m_cnt == 14*TPB + 1) begin
                        m_ph = 4; m_res = tgt;
                        if (m_shd) m_ref = 0;
                    end
                end
                4: if (fall && rd_cnv) m_ph = 5;
                5: if (cs_n) m_ph = 0;
                default: m_ph = 0;
            endcase
            m_csq = cs_n;
        end
    end

    // Compare every output with the model once per clock.
    always @(negedge clk) begin
        int eb;
        if (rst_n) begin
            eb = (m_ph != 5) ? 0 : (hb_sel ? ((m_res >> 8) & 8'h3F) : (m_res & 8'hFF));
            check(sample_hold == (m_ph == 3), "R4 hold", sample_hold, m_ph == 3);
            check(eoc_n == !(m_ph == 4 || m_ph == 5), "R4 eoc_n", eoc_n, !(m_ph == 4 || m_ph == 5));
            check(ref_en == m_ref, "R6 ref_en", ref_en, m_ref);
            check(shdn_sel == m_shd, "R6 shdn_sel", shdn_sel, m_shd);
            check(dbus_oe == (m_ph == 5), "R7 dbus_oe", dbus_oe, m_ph == 5);
            check(int'(dbus) == eb, "R8 dbus", dbus, eb);
        end
    end

    task automatic cs_low(input bit rd);
        @(negedge clk); #1; rd_cnv = rd; cs_n = 1'b0;
    endtask

    task automatic cs_high();
        @(negedge clk); #1; cs_n = 1'b1;
    endtask

    task automatic run_conv(input int code, input bit shd);
        bit was_ref;
        int cnt;
        logic [7:0] hi, lo;
        @(negedge clk);
        was_ref = ref_en;
        cs_low(1'b0); cs_high();
        @(negedge clk);
        check(ref_en == 1'b1, "R3 wake ref_en", ref_en, 1);
        if (!was_ref) begin
            cs_low(1'b0); cs_high();           // edge while reference settles
            @(negedge clk);
            check(sample_hold == 1'b0, "R3 edge during wake", sample_hold, 0);
            cnt = 0;
            while (!ref_ok && cnt < 100) begin @(negedge clk); cnt++; end
            repeat (2) @(negedge clk);
        end
        tgt = code;
        cs_low(shd); cs_high();
        cnt = 1;
        do begin @(negedge clk); cnt++; end while (eoc_n && cnt < 2000);
        check(cnt == 14*TPB + 2, "R4 conversion length", cnt, 14*TPB + 2);
        check(ref_en == !shd, "R6 ref after conversion", ref_en, !shd);
        check(shdn_sel == shd, "R6 mode latch", shdn_sel, shd);
        cs_low(1'b0);                          // wrong level for readout
        @(negedge clk);
        check(dbus_oe == 1'b0, "R10 ignored read", dbus_oe, 0);
        check(eoc_n == 1'b0, "R10 eoc held", eoc_n, 0);
        #1 cs_n = 1'b1;
        hb_sel = 1'b1;
        cs_low(1'b1);
        @(negedge clk);
        hi = dbus;
        check(dbus_oe == 1'b1, "R7 readout enable", dbus_oe, 1);
        #1 hb_sel = 1'b0;
        @(negedge clk);
        lo = dbus;
        check(hi[7:6] == 2'b00, "R8 high pad", hi, hi & 8'h3F);
        check({hi[5:0], lo} == code[13:0], "R5 result", {hi[5:0], lo}, code);
        #1 cs_n = 1'b1;
        @(negedge clk);
        check(dbus_oe == 1'b0 && eoc_n == 1'b1, "R9 release", {dbus_oe, eoc_n}, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(eoc_n == 1 && dbus_oe == 0 && dbus == 0 && ref_en == 0 &&
              shdn_sel == 1 && sample_hold == 0, "R1 reset", 
              {eoc_n, dbus_oe, ref_en, shdn_sel, sample_hold}, 5'b10010);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_low(1'b1); cs_high();
        repeat (3) @(negedge clk);
        check(ref_en == 1'b0 && sample_hold == 1'b0, "R2 ignored edge",
              {ref_en, sample_hold}, 0);
        run_conv(0, 1'b1);
        run_conv(16383, 1'b0);
        run_conv(8192, 1'b0);
        run_conv(8191, 1'b1);
        run_conv(1, 1'b1);
        run_conv(16382, 1'b0);
        run_conv(14'h2AAA, 1'b0);
        run_conv(14'h1555, 1'b1);
        run_conv(255, 1'b0);
        run_conv(256, 1'b1);
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule